// File: doc/BRIEF.md
# Multichannel ADC Engine Register File

This block is the memory-mapped register file of one analog-to-digital conversion engine that serves either 8 or 16 channels. A simple synchronous register bus drives it with a byte address, a write flag and a size flag that selects 2-byte or 4-byte accesses. Software uses the block to set the engine mode and channel enables, to program per-channel limit windows and hysteresis, and to read conversion results. Each 32-bit data word carries two channels.

The block stands in for the real converter: a read of a data word returns what is stored, and then moves both channel values forward by fixed steps. Software therefore sees a changing sample stream without an analog front end. When the block is built for 8 channels, the registers that belong to channels 8 to 15 behave like unmapped space. All write masking and control side effects are applied when the register is written, so the stored state is always legal.

Top module: `adc_engine_regs`

## Requirements
- R1: After a synchronous active-low reset, detect control (0x08) and clock control (0x0C) read 0x0000000F. Control (0x00), interrupt control (0x04) and every other register read 0.
- R2: A read request produces `rd_valid` high for exactly one cycle, on the cycle after the request, with the read data. A write request or an idle cycle leaves `rd_valid` low.
- R3: A control write stores bit 8 (init done) as a copy of bit 0 (enable) of the written value and always stores bit 5 (auto-compensation) as 0. Every other bit is stored as written, including mode in bits 3:1 and channel enables in bits 31:16.
- R4: Write masks are as follows. Data and bounds words keep bits 25:16 and 9:0. Hysteresis words also keep bit 31. Interrupt source keeps bits 15:0 and trim keeps bits 3:0. Interrupt control, detect and clock keep all 32 bits.
- R5: A read of data word n returns the stored word. The stored word then changes: the even channel (bits 9:0) becomes (value + 5) mod 1024, and the odd channel (bits 25:16) becomes (value + 7) mod 1024.
- R6: A 2-byte read (`req_size`=0) returns the upper 16 bits of the word when address bit 1 is set, and the lower 16 bits when it is clear, zero-extended. For a data word it also advances the channels as in R5.
- R7: A 2-byte write replaces only the half selected by address bit 1, keeps the other half, and then applies the masks and side effects of R3 and R4.
- R8: With NUM_CH=8, the data words at 0x20 to 0x2C, bounds at 0x50 to 0x6C and hysteresis at 0x90 to 0xAC ignore writes, read as 0 and never advance.
- R9: An offset outside the map of R11 reads as 0, and writes to it have no effect.
- R10: A misaligned access (address bit 0 set, or a 4-byte access with address bit 1 set) is ignored: it reads 0 and changes no register, and no data word advances.
- R11: The address map is as follows, and only `req_addr[7:2]` selects the word. Control is at 0x00, interrupt control at 0x04, detect at 0x08 and clock at 0x0C. Data word n (channels 2n and 2n+1) is at 0x10+4n. Bounds for channel c are at 0x30+4c and hysteresis for channel c at 0x70+4c. Interrupt source is at 0xC0 and trim at 0xC4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address in the 256-byte window |
| req_size | input | 1 | 1 = 4-byte access, 0 = 2-byte access |
| req_wdata | input | 32 | Write data (2-byte writes use bits 15:0) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data, 0 when no read completes |

## Verification
A broken channel-stepping path does not show on the first read of a data word. It shows on the second read, because the first read returns the stored value and only the next one reveals the stepped value. The bench therefore reads each data word back to back, and it checks the 10-bit wrap of both fields. A wrong control side effect or a wrong write mask shows on the first read-back after the write, one cycle after the read request. A decode error in the 8-channel build shows when a channel 8 to 15 register reads nonzero, or when a data word fails to advance, on the very next access. Two builds are compared on the same bus traffic.

// File: rtl/adc_eng_pkg.sv
// Package: shared types and constants for the ADC engine register file.
// Assumes a 256-byte window of 32-bit words indexed by address bits 7:2.
package adc_eng_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_IRQCTL,
        SEL_DETECT,
        SEL_CLOCK,
        SEL_DATA,
        SEL_BOUND,
        SEL_HYST,
        SEL_IRQSRC,
        SEL_TRIM
    } reg_sel_e;

    // Word indices (address bits 7:2)
    localparam logic [5:0] W_CTRL       = 6'd0;
    localparam logic [5:0] W_IRQCTL     = 6'd1;
    localparam logic [5:0] W_DETECT     = 6'd2;
    localparam logic [5:0] W_CLOCK      = 6'd3;
    localparam logic [5:0] W_DATA_BASE  = 6'd4;
    localparam logic [5:0] W_BOUND_BASE = 6'd12;
    localparam logic [5:0] W_HYST_BASE  = 6'd28;
    localparam logic [5:0] W_IRQSRC     = 6'd48;
    localparam logic [5:0] W_TRIM       = 6'd49;

    // Write masks
    localparam logic [31:0] MASK_PAIR   = 32'h03FF_03FF;
    localparam logic [31:0] MASK_HYST   = 32'h83FF_03FF;

    // Control bit positions
    localparam int CTRL_EN_BIT       = 0;
    localparam int CTRL_AUTOCOMP_BIT = 5;
    localparam int CTRL_INIT_BIT     = 8;

    // Reset values of detect and clock control
    localparam logic [31:0] DETECT_RST = 32'h0000_000F;
    localparam logic [31:0] CLOCK_RST  = 32'h0000_000F;

endpackage

// File: rtl/adc_eng_decode.sv
// Module: address decoder. Maps a byte address and size onto a register
// class and index. Assumes NUM_CH is 8 or 16; registers of absent channels
// and misaligned accesses decode to SEL_NONE.
module adc_eng_decode
    import adc_eng_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic [7:0] addr,
    input  logic       size_word,
    output reg_sel_e   sel,
    output logic [3:0] idx,
    output logic       misaligned
);

    localparam int NPAIR = NUM_CH / 2;
    localparam logic [5:0] DATA_END  = W_DATA_BASE  + 6'(NPAIR);
    localparam logic [5:0] BOUND_END = W_BOUND_BASE + 6'(NUM_CH);
    localparam logic [5:0] HYST_END  = W_HYST_BASE  + 6'(NUM_CH);

    logic [5:0] word;
    assign word = addr[7:2];

    // Purpose: classify the word index into one register class
    always_comb begin
        sel        = SEL_NONE;
        idx        = 4'd0;
        misaligned = addr[0] | (size_word & addr[1]);
        if (!misaligned) begin
            if (word == W_CTRL)            sel = SEL_CTRL;
            else if (word == W_IRQCTL)     sel = SEL_IRQCTL;
            else if (word == W_DETECT)     sel = SEL_DETECT;
            else if (word == W_CLOCK)      sel = SEL_CLOCK;
            else if (word >= W_DATA_BASE && word < DATA_END) begin
                sel = SEL_DATA;
                idx = 4'(word - W_DATA_BASE);
            end else if (word >= W_BOUND_BASE && word < BOUND_END) begin
                sel = SEL_BOUND;
                idx = 4'(word - W_BOUND_BASE);
            end else if (word >= W_HYST_BASE && word < HYST_END) begin
                sel = SEL_HYST;
                idx = 4'(word - W_HYST_BASE);
            end else if (word == W_IRQSRC) sel = SEL_IRQSRC;
            else if (word == W_TRIM)       sel = SEL_TRIM;
        end
    end

endmodule

// File: rtl/adc_eng_pair.sv
// Module: storage for one two-channel data word. A write loads both fields;
// a step adds a fixed increment to each field, wrapping at 2^DW.
// Assumes a write and a step never occur in the same cycle.
module adc_eng_pair #(
    parameter int DW      = 10,
    parameter int LO_STEP = 5,
    parameter int HI_STEP = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_lo,
    input  logic [DW-1:0] wr_hi,
    input  logic          step_en,
    output logic [31:0]   word
);

    logic [DW-1:0] lo_q;
    logic [DW-1:0] hi_q;

    // Purpose: load on write, advance both channels on a sampling read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_en) begin
            lo_q <= wr_lo;
            hi_q <= wr_hi;
        end else if (step_en) begin
            lo_q <= lo_q + DW'(LO_STEP);
            hi_q <= hi_q + DW'(HI_STEP);
        end
    end

    assign word = {{(16-DW){1'b0}}, hi_q, {(16-DW){1'b0}}, lo_q};

endmodule

// File: rtl/adc_eng_limits.sv
// Module: per-channel bounds and hysteresis words. Writes are masked on
// entry; reads are a combinational mux on the channel index.
// Assumes idx is below NUM_CH whenever a write enable is high.
module adc_eng_limits
    import adc_eng_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int IW    = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bnd_we,
    input  logic          hys_we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wr_word,
    output logic [31:0]   bnd_rd,
    output logic [31:0]   hys_rd
);

    logic [31:0] bnd_q [NUM_CH];
    logic [31:0] hys_q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Purpose: hold one channel's limit window and hysteresis setting
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bnd_q[c] <= '0;
                hys_q[c] <= '0;
            end else begin
                if (bnd_we && idx == IW'(c)) bnd_q[c] <= wr_word & MASK_PAIR;
                if (hys_we && idx == IW'(c)) hys_q[c] <= wr_word & MASK_HYST;
            end
        end
    end

    assign bnd_rd = bnd_q[idx];
    assign hys_rd = hys_q[idx];

endmodule

// File: rtl/adc_engine_regs.sv
// Module: top of the ADC engine register file. Decodes bus accesses,
// merges 2-byte writes, applies masks and control side effects, returns
// read data one cycle after the request and steps data words on reads.
// Assumes NUM_CH is 8 or 16 and DW is at most 16.
module adc_engine_regs
    import adc_eng_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int DW      = 10,
    parameter int LO_STEP = 5,
    parameter int HI_STEP = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic        req_size,
    input  logic [31:0] req_wdata,
    output logic        rd_valid,
    output logic [31:0] rd_data
);

    localparam int NPAIR = NUM_CH / 2;
    localparam int PW    = $clog2(NPAIR);
    localparam int IW    = $clog2(NUM_CH);

    reg_sel_e    dec_sel;
    logic [3:0]  dec_idx;
    logic        dec_misaligned;
    logic        wr_fire;
    logic        rd_fire;
    logic [31:0] cur_word;
    logic [31:0] wr_merged;
    logic [31:0] rd_shaped;
    logic [31:0] ctrl_q;
    logic [31:0] irqctl_q;
    logic [31:0] detect_q;
    logic [31:0] clock_q;
    logic [15:0] irqsrc_q;
    logic [3:0]  trim_q;
    logic [31:0] bnd_rd;
    logic [31:0] hys_rd;
    logic [31:0] pair_word [NPAIR];

    adc_eng_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr       (req_addr),
        .size_word  (req_size),
        .sel        (dec_sel),
        .idx        (dec_idx),
        .misaligned (dec_misaligned)
    );

    assign wr_fire = req_valid &  req_write;
    assign rd_fire = req_valid & ~req_write;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        adc_eng_pair #(.DW(DW), .LO_STEP(LO_STEP), .HI_STEP(HI_STEP)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_fire && dec_sel == SEL_DATA && dec_idx == 4'(p)),
            .wr_lo   (wr_merged[DW-1:0]),
            .wr_hi   (wr_merged[16 +: DW]),
            .step_en (rd_fire && dec_sel == SEL_DATA && dec_idx == 4'(p)),
            .word    (pair_word[p])
        );
    end

    adc_eng_limits #(.NUM_CH(NUM_CH)) u_limits (
        .clk     (clk),
        .rst_n   (rst_n),
        .bnd_we  (wr_fire && dec_sel == SEL_BOUND),
        .hys_we  (wr_fire && dec_sel == SEL_HYST),
        .idx     (dec_idx[IW-1:0]),
        .wr_word (wr_merged),
        .bnd_rd  (bnd_rd),
        .hys_rd  (hys_rd)
    );

    // Purpose: select the current full word of the addressed register
    always_comb begin
        unique case (dec_sel)
            SEL_CTRL:   cur_word = ctrl_q;
            SEL_IRQCTL: cur_word = irqctl_q;
            SEL_DETECT: cur_word = detect_q;
            SEL_CLOCK:  cur_word = clock_q;
            SEL_DATA:   cur_word = pair_word[dec_idx[PW-1:0]];
            SEL_BOUND:  cur_word = bnd_rd;
            SEL_HYST:   cur_word = hys_rd;
            SEL_IRQSRC: cur_word = {16'h0, irqsrc_q};
            SEL_TRIM:   cur_word = {28'h0, trim_q};
            default:    cur_word = 32'h0;
        endcase
    end

    // Purpose: merge a 2-byte write into the half chosen by address bit 1
    always_comb begin
        if (req_size)         wr_merged = req_wdata;
        else if (req_addr[1]) wr_merged = {req_wdata[15:0], cur_word[15:0]};
        else                  wr_merged = {cur_word[31:16], req_wdata[15:0]};
    end

    // Purpose: shape the read word for the access size
    always_comb begin
        if (req_size)         rd_shaped = cur_word;
        else if (req_addr[1]) rd_shaped = {16'h0, cur_word[31:16]};
        else                  rd_shaped = {16'h0, cur_word[15:0]};
    end

    // Purpose: control and global registers with write side effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            irqctl_q <= '0;
            detect_q <= DETECT_RST;
            clock_q  <= CLOCK_RST;
            irqsrc_q <= '0;
            trim_q   <= '0;
        end else if (wr_fire) begin
            unique case (dec_sel)
                SEL_CTRL: begin
                    ctrl_q                    <= wr_merged;
                    ctrl_q[CTRL_INIT_BIT]     <= wr_merged[CTRL_EN_BIT];
                    ctrl_q[CTRL_AUTOCOMP_BIT] <= 1'b0;
                end
                SEL_IRQCTL: irqctl_q <= wr_merged;
                SEL_DETECT: detect_q <= wr_merged;
                SEL_CLOCK:  clock_q  <= wr_merged;
                SEL_IRQSRC: irqsrc_q <= wr_merged[15:0];
                SEL_TRIM:   trim_q   <= wr_merged[3:0];
                default: ;
            endcase
        end
    end

    // Purpose: register read data and its valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            rd_data  <= rd_fire ? rd_shaped : 32'h0;
        end
    end

endmodule

// File: rtl/adc_engine_regs_chk.sv
// Module: assertion checker for adc_engine_regs, attached by bind.
// Assumes a synchronous active-low reset asserted from time zero.
module adc_engine_regs_chk
    import adc_eng_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        ctrl_en,
    input logic        ctrl_autocomp,
    input logic        ctrl_init,
    input reg_sel_e    dec_sel,
    input logic        dec_misaligned
);

    assert_rd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    assert_init_tracks_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_init == ctrl_en) && !ctrl_autocomp);

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && dec_sel == SEL_NONE) |=> rd_data == 32'h0);

    assert_misaligned_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && dec_misaligned) |=> rd_data == 32'h0);

endmodule

bind adc_engine_regs adc_engine_regs_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .ctrl_en        (ctrl_q[0]),
    .ctrl_autocomp  (ctrl_q[5]),
    .ctrl_init      (ctrl_q[8]),
    .dec_sel        (dec_sel),
    .dec_misaligned (dec_misaligned)
);

// File: tb/tb_adc_engine_regs.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver pushes expected read words for a 16-channel
// and an 8-channel build; a monitor pops and compares as rd_valid appears.
module tb_adc_engine_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic        req_size = 1'b1;
    logic [31:0] req_wdata = '0;
    logic        rdv16, rdv8;
    logic [31:0] rdd16, rdd8;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp16_q [$];
    logic [31:0] exp8_q  [$];
    string       tag_q   [$];

    always #2.5 clk = ~clk;

    adc_engine_regs #(.NUM_CH(16)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rdv16), .rd_data(rdd16)
    );

    adc_engine_regs #(.NUM_CH(8)) dut8 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rdv8), .rd_data(rdd8)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic sz, input logic [31:0] e16,
                      input logic [31:0] e8, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_wdata = '0;
        exp16_q.push_back(e16);
        exp8_q.push_back(e8);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
        end
    endtask

    // Monitor: pop and compare on every read strobe (R2 timing)
    always @(negedge clk) begin
        if (rst_n) begin
            if (rdv16 !== rdv8) begin
                checks++; fails++;
                $display("FAIL R2: strobe mismatch actual %b/%b expected equal", rdv16, rdv8);
            end
            if (rdv16 === 1'b1) begin
                if (exp16_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2: unexpected rd_valid actual 1 expected 0");
                end else begin
                    automatic string t = tag_q.pop_front();
                    check({t, " (16ch)"}, rdd16, exp16_q.pop_front());
                    check({t, " (8ch)"},  rdd8,  exp8_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rd_valid low in reset", {31'h0, rdv16}, 32'h0);
        rst_n = 1'b1;

        // R1: reset values
        rd(8'h00, 1'b1, 32'h0, 32'h0, "R1 control reset");
        rd(8'h04, 1'b1, 32'h0, 32'h0, "R1 irq control reset");
        rd(8'h08, 1'b1, 32'hF, 32'hF, "R1 detect reset");
        rd(8'h0C, 1'b1, 32'hF, 32'hF, "R1 clock reset");
        rd(8'h70, 1'b1, 32'h0, 32'h0, "R1 hysteresis reset");
        rd(8'hC4, 1'b1, 32'h0, 32'h0, "R1 trim reset");

        // R3: control side effects; R2: writes raise no strobe
        wr(8'h00, 1'b1, 32'hFFFF_00FF);
        idle(2);
        rd(8'h00, 1'b1, 32'hFFFF_01DF, 32'hFFFF_01DF, "R3 init follows enable, autocomp cleared");
        wr(8'h00, 1'b1, 32'h0000_010E);
        rd(8'h00, 1'b1, 32'h0000_000E, 32'h0000_000E, "R3 init cleared with enable low");

        // R4/R5: data mask, stepping and wrap, back-to-back reads
        wr(8'h10, 1'b1, 32'hFFFF_FFFF);
        rd(8'h10, 1'b1, 32'h03FF_03FF, 32'h03FF_03FF, "R4 data mask");
        rd(8'h10, 1'b1, 32'h0006_0004, 32'h0006_0004, "R5 step with wrap");
        rd(8'h10, 1'b1, 32'h000D_0009, 32'h000D_0009, "R5 second step");

        // R6: half reads
        wr(8'h14, 1'b1, 32'h0123_0045);
        rd(8'h16, 1'b0, 32'h0000_0123, 32'h0000_0123, "R6 upper half read");
        rd(8'h14, 1'b0, 32'h0000_004A, 32'h0000_004A, "R6 lower half read after step");
        rd(8'h14, 1'b1, 32'h0131_004F, 32'h0131_004F, "R6 half reads advance");

        // R7: half write keeps other half
        wr(8'h12, 1'b0, 32'h0000_0155);
        rd(8'h10, 1'b1, 32'h0155_000E, 32'h0155_000E, "R7 upper half write merge");
        wr(8'h08, 1'b1, 32'h1234_5678);
        wr(8'h08, 1'b0, 32'h0000_ABCD);
        rd(8'h0A, 1'b0, 32'h0000_1234, 32'h0000_1234, "R7 detect upper kept");
        rd(8'h08, 1'b0, 32'h0000_ABCD, 32'h0000_ABCD, "R7 detect lower replaced");

        // R10: misaligned accesses ignored
        rd(8'h12, 1'b1, 32'h0, 32'h0, "R10 misaligned word read");
        rd(8'h10, 1'b1, 32'h015C_0013, 32'h015C_0013, "R10 no step on misaligned read");
        wr(8'h01, 1'b1, 32'hFFFF_FFFF);
        rd(8'h00, 1'b1, 32'h0000_000E, 32'h0000_000E, "R10 misaligned write ignored");

        // R4/R8: limits, high channels
        wr(8'h3C, 1'b1, 32'hFFFF_FFFF);
        wr(8'h78, 1'b1, 32'hFFFF_FFFF);
        wr(8'hAC, 1'b1, 32'hFFFF_FFFF);
        wr(8'h50, 1'b1, 32'hFFFF_FFFF);
        wr(8'h2C, 1'b1, 32'h00AA_00BB);
        rd(8'h3C, 1'b1, 32'h03FF_03FF, 32'h03FF_03FF, "R4 bounds mask");
        rd(8'h78, 1'b1, 32'h83FF_03FF, 32'h83FF_03FF, "R4 hysteresis mask");
        rd(8'hAC, 1'b1, 32'h83FF_03FF, 32'h0, "R8 hysteresis ch15");
        rd(8'h50, 1'b1, 32'h03FF_03FF, 32'h0, "R8 bounds ch8");
        rd(8'h2C, 1'b1, 32'h00AA_00BB, 32'h0, "R8 data word 7");
        rd(8'h2C, 1'b1, 32'h00B1_00C0, 32'h0, "R8 data word 7 step");

        // R4: global masks
        wr(8'hC0, 1'b1, 32'hFFFF_FFFF);
        wr(8'hC4, 1'b1, 32'hFFFF_FFFF);
        wr(8'h04, 1'b1, 32'hDEAD_BEEF);
        rd(8'hC0, 1'b1, 32'h0000_FFFF, 32'h0000_FFFF, "R4 irq source mask");
        rd(8'hC4, 1'b1, 32'h0000_000F, 32'h0000_000F, "R4 trim mask");
        rd(8'h04, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R4 irq control full");

        // R9/R11: unmapped offsets
        wr(8'hB0, 1'b1, 32'hFFFF_FFFF);
        wr(8'hC8, 1'b1, 32'hFFFF_FFFF);
        rd(8'hB0, 1'b1, 32'h0, 32'h0, "R9 gap 0xB0");
        rd(8'hC8, 1'b1, 32'h0, 32'h0, "R9 offset 0xC8");
        rd(8'hFC, 1'b1, 32'h0, 32'h0, "R9 top offset");
        rd(8'h0C, 1'b1, 32'hF, 32'hF, "R11 clock untouched by stray writes");

        idle(4);
        check("R2 all reads answered", 32'(exp16_q.size()), 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule